// File: doc/BRIEF.md
# SPI Slave Shift Engine with Transmit Queue

This block is the serial end of an SPI slave. It samples the master's clock, select and data lines in the system clock domain and shifts 8-bit bytes in and out, most significant bit first. All four polarity and phase settings are supported. On the parallel side, software or a neighbouring block places the next outgoing byte in a one-entry queue. Each received byte is announced with a one-cycle strobe, and sticky flags report lost receive data and transmit starvation.

The phase setting decides how bytes are framed. With phase 0, every byte is opened by a falling edge of the select line. The first bit is presented on MISO before any clock edge arrives. The select line must be released and asserted again before the next byte. With phase 1, the first leading clock edge of a byte opens it. The select line may stay low over any number of bytes, and each byte follows the previous one directly. Polarity only sets the idle level of the clock, and with it which edge counts as leading.

Top module: `spi_slave_txq`

## Requirements
- R1: A byte is 8 bits, most significant bit first. One system clock after the eighth capture, `rx_valid_o` is high for exactly one cycle. `rx_data_o` then holds the received byte and keeps it until the next byte completes.
- R2: With `cfg_cpha`=0, a falling edge on `ss_n_i` opens a byte and loads its first bit onto `miso_o` before the first clock edge. MOSI is captured on each leading edge, and MISO moves to the next bit on each trailing edge.
- R3: With `cfg_cpha`=0, once 8 bits have been captured, further SCK edges are ignored until `ss_n_i` goes high and low again. There is no further `rx_valid_o`, `rx_data_o` is kept, and `miso_o` stays at the last bit sent.
- R4: With `cfg_cpha`=1, the first leading edge while selected opens a byte and drives its first bit. MOSI is captured on trailing edges. After the eighth capture, the next leading edge opens a new byte without any change on `ss_n_i`.
- R5: `cfg_cpol`=0 makes the rising SCK edge the leading edge. `cfg_cpol`=1 makes the falling edge leading. Bit order and the framing rules are the same in both cases.
- R6: A `tx_wr_i` pulse stores `tx_data_i` in the queue and raises `tx_full_o`. The queued byte is loaded when the next byte opens, and `tx_full_o` then clears. A byte queued during a transfer is sent as the very next byte.
- R7: If the queue is empty when a byte opens, the last loaded byte is sent again (0x00 after reset) and `tx_udr_o` is set. `tx_udr_o` stays set until `flag_clr_i`.
- R8: If a byte completes before the previous one was acknowledged with `rx_rd_i`, `rx_ovr_o` is set. It stays set until `flag_clr_i`.
- R9: While `ss_n_i` is high, `miso_oe_o` is 0 and the bit count returns to zero. A byte cut short by `ss_n_i` rising produces no `rx_valid_o`, and the next byte starts again from its first bit.
- R10: After reset, `miso_oe_o`, `rx_valid_o`, `tx_full_o`, `rx_ovr_o` and `tx_udr_o` are 0 and `rx_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Clock idle level: 0 low, 1 high |
| cfg_cpha | input | 1 | Phase: 0 capture on leading edge, 1 capture on trailing edge |
| sck_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for MISO, high while selected |
| tx_data_i | input | 8 | Byte to queue for transmission |
| tx_wr_i | input | 1 | Write strobe for the transmit queue |
| tx_full_o | output | 1 | Queue holds a byte that has not been loaded yet |
| rx_valid_o | output | 1 | One-cycle strobe marking a completed received byte |
| rx_data_o | output | 8 | Last received byte |
| rx_rd_i | input | 1 | Acknowledges the received byte |
| rx_ovr_o | output | 1 | Sticky receive overrun flag |
| tx_udr_o | output | 1 | Sticky transmit underrun flag |
| flag_clr_i | input | 1 | Clears both sticky flags |

## Verification
The hardest case to reach is a phase-1 stream with the select line held low, where a new byte is queued while the current byte is half shifted. The stimulus splits one transfer in two and pulses the queue write between the halves. It then clocks a second byte with no gap and checks that the queued value appears on MISO from its first bit. The second hard case is the extra clock edges in phase 0 after the eighth bit without a select toggle. The bench clocks a full extra byte there and expects no strobe and a MISO line frozen at the last bit. A behavioural model tracks every cycle of the run, including an aborted byte and the resending of a byte from an empty queue.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;

   // events seen on the synchronised serial lines for one system clock
   typedef struct packed {
      logic lead;     // leading SCK edge (rising for cpol 0)
      logic trail;    // trailing SCK edge
      logic ss_fall;  // select just asserted
      logic ss_act;   // select currently asserted
   } spi_evt_t;

   // bit positions inside the synchroniser bundle
   localparam int unsigned PIN_SCK  = 0;
   localparam int unsigned PIN_SS   = 1;
   localparam int unsigned PIN_MOSI = 2;
   localparam int unsigned PIN_CNT  = 3;

endpackage

// File: rtl/spi_txq_sync.sv
module spi_txq_sync #(
   parameter int unsigned             W       = 3,
   parameter int unsigned             STAGES  = 2,
   parameter logic [W-1:0]            RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (STAGES >= 2) else $error("spi_txq_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/spi_txq_edge.sv
module spi_txq_edge
   import spi_txq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cpol,
   input  logic     sck_s,
   input  logic     ss_n_s,
   output spi_evt_t evt
);

   logic sck_d, ss_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         ss_d  <= 1'b1;
      end else begin
         sck_d <= sck_s;
         ss_d  <= ss_n_s;
      end
   end

   logic rise, fall;
   assign rise = sck_s & ~sck_d;
   assign fall = ~sck_s & sck_d;

   always_comb begin
      evt.lead    = cpol ? fall : rise;
      evt.trail   = cpol ? rise : fall;
      evt.ss_fall = ss_d & ~ss_n_s;
      evt.ss_act  = ~ss_n_s;
   end

endmodule

// File: rtl/spi_txq_engine.sv
module spi_txq_engine
   import spi_txq_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpha,
   input  spi_evt_t          evt,
   input  logic              mosi_s,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en,
   output logic              miso,
   output logic              q_full,
   output logic              done_evt,
   output logic              udr_evt,
   output logic              rx_strobe,
   output logic [DATA_W-1:0] rx_byte
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(DATA_W);

   logic [DATA_W-1:0] tx_sh, rx_sh, last_q, q_data, next_byte;
   logic              q_vld;
   logic [CNT_W-1:0]  cnt;
   logic              start, capture, shift;

   always_comb begin
      if (cpha) begin
         start   = evt.ss_act & evt.lead & (cnt == '0);
         capture = evt.ss_act & evt.trail;
         shift   = evt.ss_act & evt.lead & (cnt != '0);
      end else begin
         start   = evt.ss_fall;
         capture = evt.ss_act & evt.lead & (cnt != ALL_BITS);
         shift   = evt.ss_act & evt.trail & (cnt != ALL_BITS) & (cnt != '0);
      end
   end

   assign next_byte = q_vld ? q_data : last_q;
   assign done_evt  = capture & (cnt == LAST_BIT);
   assign udr_evt   = start & ~q_vld;
   assign miso      = tx_sh[DATA_W-1];
   assign q_full    = q_vld;

   // bit counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!evt.ss_act)  cnt <= '0;
      else if (start)        cnt <= '0;
      else if (capture)      cnt <= (cpha && cnt == LAST_BIT) ? '0 : cnt + 1'b1;
   end

   // transmit side and one-entry queue
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh  <= '0;
         last_q <= '0;
         q_data <= '0;
         q_vld  <= 1'b0;
      end else begin
         if (start) begin
            tx_sh  <= next_byte;
            last_q <= next_byte;
            q_vld  <= wr_en;
         end else begin
            if (shift) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            if (wr_en) q_vld <= 1'b1;
         end
         if (wr_en) q_data <= wr_data;
      end
   end

   // receive side
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh     <= '0;
         rx_byte   <= '0;
         rx_strobe <= 1'b0;
      end else begin
         rx_strobe <= done_evt;
         if (capture)  rx_sh   <= {rx_sh[DATA_W-2:0], mosi_s};
         if (done_evt) rx_byte <= {rx_sh[DATA_W-2:0], mosi_s};
      end
   end

   // R9
   ss_idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt.ss_act |=> cnt == '0);

   // R3
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpha && evt.ss_act && cnt == ALL_BITS) |=> (cnt == ALL_BITS || cnt == '0));

   // R6
   q_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> q_vld);

   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> !rx_strobe);

endmodule

// File: rtl/spi_slave_txq.sv
module spi_slave_txq
   import spi_txq_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              sck_i,
   input  logic              ss_n_i,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              miso_oe_o,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              tx_wr_i,
   output logic              tx_full_o,
   output logic              rx_valid_o,
   output logic [DATA_W-1:0] rx_data_o,
   input  logic              rx_rd_i,
   output logic              rx_ovr_o,
   output logic              tx_udr_o,
   input  logic              flag_clr_i
);

   initial begin
      assert (DATA_W >= 2) else $error("spi_slave_txq: DATA_W must be at least 2");
   end

   localparam logic [PIN_CNT-1:0] PIN_RST = PIN_CNT'(1) << PIN_SS;

   logic [PIN_CNT-1:0] pins_raw, pins_s;
   spi_evt_t           evt;
   logic               done_evt, udr_evt, rx_unread;

   always_comb begin
      pins_raw           = '0;
      pins_raw[PIN_SCK]  = sck_i;
      pins_raw[PIN_SS]   = ss_n_i;
      pins_raw[PIN_MOSI] = mosi_i;
   end

   spi_txq_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk (clk), .rst_n (rst_n), .d (pins_raw), .q (pins_s)
   );

   spi_txq_edge u_edge (
      .clk (clk), .rst_n (rst_n), .cpol (cfg_cpol),
      .sck_s (pins_s[PIN_SCK]), .ss_n_s (pins_s[PIN_SS]), .evt (evt)
   );

   spi_txq_engine #(.DATA_W(DATA_W)) u_eng (
      .clk (clk), .rst_n (rst_n), .cpha (cfg_cpha), .evt (evt),
      .mosi_s (pins_s[PIN_MOSI]), .wr_data (tx_data_i), .wr_en (tx_wr_i),
      .miso (miso_o), .q_full (tx_full_o), .done_evt (done_evt),
      .udr_evt (udr_evt), .rx_strobe (rx_valid_o), .rx_byte (rx_data_o)
   );

   assign miso_oe_o = evt.ss_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_unread <= 1'b0;
         rx_ovr_o  <= 1'b0;
         tx_udr_o  <= 1'b0;
      end else begin
         if (flag_clr_i) begin
            rx_ovr_o <= 1'b0;
            tx_udr_o <= 1'b0;
         end
         if (done_evt && rx_unread && !rx_rd_i) rx_ovr_o <= 1'b1;
         if (udr_evt) tx_udr_o <= 1'b1;
         if (done_evt)     rx_unread <= 1'b1;
         else if (rx_rd_i) rx_unread <= 1'b0;
      end
   end

   // R7
   udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_udr_o && !flag_clr_i) |=> tx_udr_o);

   // R8
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovr_o && !flag_clr_i) |=> rx_ovr_o);

   // R9
   oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_n_i) |=> ##2 !miso_oe_o);

endmodule

// File: tb/sim_spi_slave_txq.sv
module sim_spi_slave_txq;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpol = 1'b0, cpha = 1'b0;
   logic sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
   logic [7:0] wdat = 8'h00;
   logic wr = 1'b0, rd = 1'b0, clr = 1'b0;
   logic miso, oe, full, rxv, ovr, udr;
   logic [7:0] rxd;

   int n_chk = 0, n_bad = 0, n_pulse = 0;

   always #5 clk = ~clk;

   spi_slave_txq u0 (
      .clk (clk), .rst_n (rst_n), .cfg_cpol (cpol), .cfg_cpha (cpha),
      .sck_i (sck), .ss_n_i (ss_n), .mosi_i (mosi), .miso_o (miso),
      .miso_oe_o (oe), .tx_data_i (wdat), .tx_wr_i (wr), .tx_full_o (full),
      .rx_valid_o (rxv), .rx_data_o (rxd), .rx_rd_i (rd), .rx_ovr_o (ovr),
      .tx_udr_o (udr), .flag_clr_i (clr)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   // pins reach the decision logic after a fixed sampling delay
   bit hk[3], hs[3], hm[3];
   int m_cnt;
   logic [7:0] m_tx, m_rx, m_last, m_q, m_rxd;
   bit m_qv, m_rxv, m_unread, m_ovr, m_udr, m_oe;

   always @(posedge clk) begin
      if (!rst_n) begin
         hk = '{0, 0, 0}; hs = '{1, 1, 1}; hm = '{0, 0, 0};
         m_cnt = 0; m_tx = 0; m_rx = 0; m_last = 0; m_q = 0; m_rxd = 0;
         m_qv = 0; m_rxv = 0; m_unread = 0; m_ovr = 0; m_udr = 0; m_oe = 0;
      end else begin
         bit act, up, dn, ld, tr, opn, cap, shf, fin;
         logic [7:0] nb;
         act = !hs[1];
         up  = hk[1] && !hk[2];
         dn  = !hk[1] && hk[2];
         ld  = cpol ? dn : up;
         tr  = cpol ? up : dn;
         if (cpha) begin
            opn = act && ld && m_cnt == 0;
            cap = act && tr;
            shf = act && ld && m_cnt != 0;
         end else begin
            opn = hs[2] && !hs[1];
            cap = act && ld && m_cnt < 8;
            shf = act && tr && m_cnt > 0 && m_cnt < 8;
         end
         fin = cap && m_cnt == 7;
         if (fin) m_rxd = {m_rx[6:0], hm[1]};
         if (clr) begin m_ovr = 0; m_udr = 0; end
         if (fin && m_unread && !rd) m_ovr = 1;
         if (opn && !m_qv) m_udr = 1;
         if (fin) m_unread = 1; else if (rd) m_unread = 0;
         if (opn) begin
            nb = m_qv ? m_q : m_last;
            m_tx = nb; m_last = nb; m_qv = wr;
         end else begin
            if (shf) m_tx = {m_tx[6:0], 1'b0};
            if (wr) m_qv = 1;
         end
         if (wr) m_q = wdat;
         if (cap) m_rx = {m_rx[6:0], hm[1]};
         if (!act || opn) m_cnt = 0;
         else if (cap) m_cnt = (cpha && m_cnt == 7) ? 0 : m_cnt + 1;
         m_rxv = fin;
         hk[2] = hk[1]; hk[1] = hk[0]; hk[0] = sck;
         hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = ss_n;
         hm[2] = hm[1]; hm[1] = hm[0]; hm[0] = mosi;
         m_oe = !hs[1];
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rxv) n_pulse++;
      chk(oe == m_oe, "R9 miso_oe", oe, m_oe);
      if (m_oe) chk(miso == m_tx[7], "R2 miso", miso, m_tx[7]);
      chk(rxv == m_rxv, "R1 rx_valid", rxv, m_rxv);
      chk(rxd == m_rxd, "R1 rx_data", rxd, m_rxd);
      chk(full == m_qv, "R6 tx_full", full, m_qv);
      chk(ovr == m_ovr, "R8 rx_ovr", ovr, m_ovr);
      chk(udr == m_udr, "R7 tx_udr", udr, m_udr);
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_mode(input bit pol, input bit pha);
      ss_n = 1'b1; cpol = pol; cpha = pha; sck = pol;
      tick(8);
   endtask

   task automatic qwrite(input logic [7:0] d);
      wdat = d; wr = 1'b1; tick(1); wr = 1'b0;
   endtask

   task automatic pulse_rd_clr();
      rd = 1'b1; clr = 1'b1; tick(1); rd = 1'b0; clr = 1'b0; tick(1);
   endtask

   task automatic xfer(input logic [7:0] mo, ref logic [7:0] mi, input int first, input int last);
      for (int i = first; i < last; i++) begin
         if (!cpha) begin
            mosi = mo[7-i]; tick(4); mi[7-i] = miso; sck = ~sck; tick(4); sck = ~sck;
         end else begin
            sck = ~sck; mosi = mo[7-i]; tick(4); mi[7-i] = miso; sck = ~sck; tick(4);
         end
      end
      tick(4);
   endtask

   task automatic select();
      ss_n = 1'b0; tick(4);
   endtask

   task automatic release_ss();
      ss_n = 1'b1; tick(6);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   // ---------------- directed sequence ----------------
   initial begin
      logic [7:0] mi;
      int p0;
      mi = 8'h00;
      tick(4);
      rst_n = 1'b1;
      tick(2);
      // R10 reset state
      chk(oe == 1'b0 && rxv == 1'b0 && full == 1'b0, "R10 idle outputs", {oe, rxv, full}, 0);
      chk(ovr == 1'b0 && udr == 1'b0 && rxd == 8'h00, "R10 flags and data", {ovr, udr, rxd}, 0);

      // mode 0: queued byte, phase-0 framing
      set_mode(1'b0, 1'b0);
      qwrite(8'hA5);
      chk(full == 1'b1, "R6 queue full after write", full, 1);
      select();
      chk(full == 1'b0, "R6 queue consumed at open", full, 0);
      chk(miso == 1'b1, "R2 msb before first edge", miso, 1);
      xfer(8'h3C, mi, 0, 8);
      chk(mi == 8'hA5, "R2 byte seen by master", mi, 8'hA5);
      chk(rxd == 8'h3C, "R1 byte received", rxd, 8'h3C);
      chk(udr == 1'b0, "R7 no underrun when queued", udr, 0);
      release_ss();

      // empty queue: resend, underrun, overrun (first byte never read)
      select();
      xfer(8'h81, mi, 0, 8);
      chk(mi == 8'hA5, "R7 last byte resent", mi, 8'hA5);
      chk(udr == 1'b1, "R7 underrun flagged", udr, 1);
      chk(ovr == 1'b1, "R8 overrun flagged", ovr, 1);
      pulse_rd_clr();
      chk(ovr == 1'b0 && udr == 1'b0, "R8 flags cleared", {ovr, udr}, 0);
      release_ss();

      // R3: extra edges after eight bits without a select toggle
      qwrite(8'h11);
      select();
      xfer(8'hF0, mi, 0, 8);
      rd = 1'b1; tick(1); rd = 1'b0;
      p0 = n_pulse;
      xfer(8'h0F, mi, 0, 8);
      chk(mi == 8'hFF, "R3 miso frozen at last bit", mi, 8'hFF);
      chk(n_pulse == p0, "R3 no strobe on extra edges", n_pulse, p0);
      chk(rxd == 8'hF0, "R3 data kept", rxd, 8'hF0);
      release_ss();

      // R9: abort mid-byte, then a fresh byte from bit 0
      qwrite(8'h77);
      select();
      p0 = n_pulse;
      xfer(8'hE0, mi, 0, 3);
      release_ss();
      chk(oe == 1'b0, "R9 output released", oe, 0);
      chk(n_pulse == p0, "R9 no strobe on abort", n_pulse, p0);
      select();
      xfer(8'h5E, mi, 0, 8);
      chk(mi == 8'h77, "R9 restart from first bit", mi, 8'h77);
      chk(rxd == 8'h5E, "R9 full byte after abort", rxd, 8'h5E);
      pulse_rd_clr();
      release_ss();

      // mode 3: phase-1 stream with select held low and a mid-byte queue write
      set_mode(1'b1, 1'b1);
      qwrite(8'h96);
      select();
      xfer(8'h24, mi, 0, 4);
      qwrite(8'h5A);
      xfer(8'h24, mi, 4, 8);
      chk(mi == 8'h96, "R4 first streamed byte", mi, 8'h96);
      chk(rxd == 8'h24, "R4 first byte received", rxd, 8'h24);
      chk(full == 1'b1, "R6 mid-byte write waits", full, 1);
      xfer(8'hC3, mi, 0, 8);
      chk(mi == 8'h5A, "R6 queued byte sent next", mi, 8'h5A);
      chk(rxd == 8'hC3, "R4 second byte without toggle", rxd, 8'hC3);
      chk(ovr == 1'b1, "R8 overrun in stream", ovr, 1);
      pulse_rd_clr();
      release_ss();

      // R5: remaining polarity/phase pairs
      set_mode(1'b0, 1'b1);
      qwrite(8'h69);
      select();
      xfer(8'hB4, mi, 0, 8);
      chk(mi == 8'h69, "R5 cpol0 cpha1 transmit", mi, 8'h69);
      chk(rxd == 8'hB4, "R5 cpol0 cpha1 receive", rxd, 8'hB4);
      pulse_rd_clr();
      release_ss();

      set_mode(1'b1, 1'b0);
      qwrite(8'hD2);
      select();
      xfer(8'h4B, mi, 0, 8);
      chk(mi == 8'hD2, "R5 cpol1 cpha0 transmit", mi, 8'hD2);
      chk(rxd == 8'h4B, "R5 cpol1 cpha0 receive", rxd, 8'h4B);
      release_ss();

      tick(4);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule